// File: doc/BRIEF.md
# Pre-boot command stream interpreter

This block walks through a boot image held in memory, one 32-bit word at a time, and executes a small command language before the rest of the system starts. The commands are a plain register write, a conditional load, a conditional jump, an unconditional jump and an end marker. A conditional load reads a register, masks the value and keeps the result as a branch condition. A conditional jump then moves forward in the stream when that held value equals a constant. With these commands one fixed script can skip groups of register writes, depending on a device revision field or on a configuration field.

The block has three interfaces. The word-fetch port sends a byte address and gets back a word. The register bus master performs single reads and writes. The control interface has a start pulse with a start address, and two status outputs, done and error, which stay set while the block is halted.

Top module: `boot_seq_engine`

## Requirements
- R1: After reset, done, error, fetch_req and bus_req are low and the condition register is zero. A start pulse accepted while idle, done or in error makes the first fetch at start_addr and clears the condition register to zero.
- R2: A command whose first word has bit 31 clear is a write. That first word is the register address and the next word is the data. The block issues exactly one bus write with bus_we high, and it fetches no further word until bus_ack returns.
- R3: The word 0x80140000 starts a conditional load of three words: header, register address, mask. The block makes one bus read of that address and keeps bus_rdata AND mask as the condition value.
- R4: The word 0x80850000 starts a conditional jump of three words: header, byte offset, compare value. The jump is taken only when the held condition equals the compare value. When it is not taken, execution continues 12 bytes after the header.
- R5: The word 0x80840000 starts an unconditional jump of two words: header and byte offset. It is always taken.
- R6: A jump offset counts bytes from the address of the jump's own header word. For example, an offset of 0x14 on a conditional jump lands just past a following two-word jump.
- R7: On any jump command, taken or not, an offset that is zero or not a multiple of 4 puts the block in error. After that it makes no further fetch or bus access.
- R8: The word 0x80FF0000 ends the stream. It sets done and the block halts.
- R9: Any other word with bit 31 set, met where a command header is expected, sets error and halts the block.
- R10: The fetch and bus requests each stay high, with stable address and data, until their acknowledge arrives. The two requests are never high at the same time, and every fetch address is word aligned. Each word of a command is fetched exactly once.
- R11: Done and error are never set together. Each one holds until the next accepted start, and a start pulse is ignored while a stream is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin executing at start_addr (accepted when not running) |
| start_addr | input | AW | Byte address of the first command |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | AW | Byte address of the requested word |
| fetch_ack | input | 1 | Fetch completed; fetch_data is valid |
| fetch_data | input | 32 | Fetched word |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Bus access completed; bus_rdata valid on reads |
| bus_rdata | input | 32 | Read data |
| done | output | 1 | End marker reached |
| error | output | 1 | Unknown header or bad jump offset met |

## Verification
The hardest case to reach from the ports is a conditional jump whose outcome depends on a register value that the script itself wrote earlier, so that a write, a load and a jump interact across several commands. Random scripts are built from valid command boundaries. Jump targets are picked among later commands, and write data and compare values come from the same small set of revision-like values under mask 0xF0, so taken and not-taken branches both occur often. Directed scripts add the skip-one-jump offset, bad offsets, an unknown header and the cleared condition after start, while fetch and bus acknowledges arrive after random delays.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    localparam logic [31:0] HDR_LOADC = 32'h8014_0000;
    localparam logic [31:0] HDR_JUMPC = 32'h8085_0000;
    localparam logic [31:0] HDR_JUMP  = 32'h8084_0000;
    localparam logic [31:0] HDR_END   = 32'h80FF_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_BUS,
        ST_DONE,
        ST_ERR
    } state_e;

    typedef enum logic [2:0] {
        K_WRITE,
        K_LOADC,
        K_JUMPC,
        K_JUMP,
        K_END,
        K_BAD
    } kind_e;

endpackage

// File: rtl/boot_seq_decode.sv
module boot_seq_decode
    import boot_seq_pkg::*;
(
    input  logic [31:0] hdr,
    output kind_e       kind,
    output logic [1:0]  nwords
);
    always_comb begin
        kind   = K_BAD;
        nwords = 2'd1;
        if (!hdr[31]) begin
            kind   = K_WRITE;
            nwords = 2'd2;
        end else begin
            case (hdr)
                HDR_LOADC: begin kind = K_LOADC; nwords = 2'd3; end
                HDR_JUMPC: begin kind = K_JUMPC; nwords = 2'd3; end
                HDR_JUMP:  begin kind = K_JUMP;  nwords = 2'd2; end
                HDR_END:   begin kind = K_END;   nwords = 2'd1; end
                default:   begin kind = K_BAD;   nwords = 2'd1; end
            endcase
        end
    end
endmodule

// File: rtl/boot_seq_jump.sv
module boot_seq_jump #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [31:0]   offset,
    output logic          ok,
    output logic [AW-1:0] target
);
    logic fits;

    generate
        if (AW < 32) begin : g_narrow
            assign fits = (offset[31:AW] == '0);
        end else begin : g_full
            assign fits = 1'b1;
        end
    endgenerate

    assign ok     = fits && (offset != 32'd0) && (offset[1:0] == 2'b00);
    assign target = base + offset[AW-1:0];
endmodule

// File: rtl/boot_seq_cond.sv
module boot_seq_cond (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        load,
    input  logic [31:0] value,
    input  logic [31:0] cmp,
    output logic        match
);
    logic [31:0] cond_d, cond_q;

    always_comb begin
        cond_d = cond_q;
        if (clr) begin
            cond_d = 32'd0;
        end else if (load) begin
            cond_d = value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 32'd0;
        end else begin
            cond_q <= cond_d;
        end
    end

    assign match = (cond_q == cmp);
endmodule

// File: rtl/boot_seq_engine.sv
module boot_seq_engine
    import boot_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_ack,
    input  logic [31:0]   fetch_data,
    output logic          bus_req,
    output logic          bus_we,
    output logic [31:0]   bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic          bus_ack,
    input  logic [31:0]   bus_rdata,
    output logic          done,
    output logic          error
);
    localparam int WORD_BYTES = 4;
    localparam int CMD3_BYTES = 3 * WORD_BYTES;

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] base;
        logic [1:0]    widx;
        kind_e         kind;
        logic [1:0]    nw;
        logic [31:0]   w0;
        logic [31:0]   w1;
        logic [31:0]   w2;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    kind_e         dec_kind;
    logic [1:0]    dec_nw;
    logic          jmp_ok;
    logic [AW-1:0] jmp_target;
    logic          cond_clr;
    logic          cond_load;
    logic          cond_match;

    boot_seq_decode u_decode (
        .hdr    (fetch_data),
        .kind   (dec_kind),
        .nwords (dec_nw)
    );

    boot_seq_jump #(.AW(AW)) u_jump (
        .base   (ctx_q.base),
        .offset (ctx_q.w1),
        .ok     (jmp_ok),
        .target (jmp_target)
    );

    boot_seq_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cond_clr),
        .load  (cond_load),
        .value (bus_rdata & ctx_q.w2),
        .cmp   (ctx_q.w2),
        .match (cond_match)
    );

    always_comb begin
        ctx_d     = ctx_q;
        cond_clr  = 1'b0;
        cond_load = 1'b0;
        case (ctx_q.st)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (start) begin
                    ctx_d.st   = ST_FETCH;
                    ctx_d.base = start_addr;
                    ctx_d.widx = 2'd0;
                    cond_clr   = 1'b1;
                end
            end
            ST_FETCH: begin
                if (fetch_ack) begin
                    if (ctx_q.widx == 2'd0) begin
                        ctx_d.w0   = fetch_data;
                        ctx_d.kind = dec_kind;
                        ctx_d.nw   = dec_nw;
                        if (dec_kind == K_END) begin
                            ctx_d.st = ST_DONE;
                        end else if (dec_kind == K_BAD) begin
                            ctx_d.st = ST_ERR;
                        end else begin
                            ctx_d.widx = 2'd1;
                        end
                    end else begin
                        if (ctx_q.widx == 2'd1) begin
                            ctx_d.w1 = fetch_data;
                        end else begin
                            ctx_d.w2 = fetch_data;
                        end
                        if (ctx_q.widx + 2'd1 == ctx_q.nw) begin
                            ctx_d.st = ST_EXEC;
                        end else begin
                            ctx_d.widx = ctx_q.widx + 2'd1;
                        end
                    end
                end
            end
            ST_EXEC: begin
                case (ctx_q.kind)
                    K_WRITE, K_LOADC: ctx_d.st = ST_BUS;
                    K_JUMPC, K_JUMP: begin
                        if (!jmp_ok) begin
                            ctx_d.st = ST_ERR;
                        end else begin
                            ctx_d.st   = ST_FETCH;
                            ctx_d.widx = 2'd0;
                            if (ctx_q.kind == K_JUMP || cond_match) begin
                                ctx_d.base = jmp_target;
                            end else begin
                                ctx_d.base = ctx_q.base + AW'(CMD3_BYTES);
                            end
                        end
                    end
                    default: ctx_d.st = ST_ERR;
                endcase
            end
            ST_BUS: begin
                if (bus_ack) begin
                    cond_load  = (ctx_q.kind == K_LOADC);
                    ctx_d.st   = ST_FETCH;
                    ctx_d.widx = 2'd0;
                    ctx_d.base = ctx_q.base + AW'({ctx_q.nw, 2'b00});
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q.st   <= ST_IDLE;
            ctx_q.base <= '0;
            ctx_q.widx <= 2'd0;
            ctx_q.kind <= K_WRITE;
            ctx_q.nw   <= 2'd0;
            ctx_q.w0   <= 32'd0;
            ctx_q.w1   <= 32'd0;
            ctx_q.w2   <= 32'd0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign fetch_req  = (ctx_q.st == ST_FETCH);
    assign fetch_addr = ctx_q.base + AW'({ctx_q.widx, 2'b00});
    assign bus_req    = (ctx_q.st == ST_BUS);
    assign bus_we     = (ctx_q.kind == K_WRITE);
    assign bus_addr   = (ctx_q.kind == K_WRITE) ? ctx_q.w0 : ctx_q.w1;
    assign bus_wdata  = ctx_q.w1;
    assign done       = (ctx_q.st == ST_DONE);
    assign error      = (ctx_q.st == ST_ERR);
endmodule

// File: rtl/boot_seq_engine_chk.sv
module boot_seq_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          fetch_req,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_ack,
    input logic          bus_req,
    input logic          bus_we,
    input logic [31:0]   bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          bus_ack,
    input logic          done,
    input logic          error
);
    assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_addr));

    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    assert_one_master_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req && bus_req));

    assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> fetch_addr[1:0] == 2'b00);

    assert_err_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error && !fetch_req && !bus_req);

    assert_done_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && !fetch_req && !bus_req);

    assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
endmodule

bind boot_seq_engine boot_seq_engine_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .fetch_ack  (fetch_ack),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .done       (done),
    .error      (error)
);

// File: tb/boot_seq_engine_tb.sv
module boot_seq_engine_tb;
    localparam int AW = 32;
    localparam logic [31:0] H_LOADC = 32'h8014_0000;
    localparam logic [31:0] H_JUMPC = 32'h8085_0000;
    localparam logic [31:0] H_JUMP  = 32'h8084_0000;
    localparam logic [31:0] H_END   = 32'h80FF_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          fetch_ack = 1'b0;
    logic [31:0]   fetch_data = 32'd0;
    logic          bus_req;
    logic          bus_we;
    logic [31:0]   bus_addr;
    logic [31:0]   bus_wdata;
    logic          bus_ack = 1'b0;
    logic [31:0]   bus_rdata = 32'd0;
    logic          done;
    logic          error;

    always #5 clk = ~clk;

    boot_seq_engine #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .error(error)
    );

    int total = 0;
    int bad = 0;

    logic [31:0] mem [256];
    logic [31:0] regs [16];
    logic [31:0] act_addr [64];
    logic [31:0] act_data [64];
    int          nact = 0;
    int          nfetch = 0;
    int          overlap = 0;
    bit          first_seen = 1'b0;
    logic [31:0] first_faddr = 32'd0;
    logic [31:0] exp_addr [64];
    logic [31:0] exp_data [64];
    int          cur = 0;

    function automatic logic [31:0] init_reg(int i);
        return 32'h1200_0000 | (i << 4);
    endfunction

    function automatic logic [31:0] mrd(logic [31:0] a);
        if (a >= 32'd1024) return 32'hFFFF_FFFF;
        return mem[a[9:2]];
    endfunction

    // Memory and register models; acknowledges after random delays.
    always @(negedge clk) begin
        fetch_ack <= 1'b0;
        bus_ack   <= 1'b0;
        if (fetch_req && bus_req) overlap++;
        if (fetch_req && !first_seen) begin
            first_seen  = 1'b1;
            first_faddr = fetch_addr;
        end
        if (fetch_req && !fetch_ack && ($urandom % 3 != 0)) begin
            fetch_ack  <= 1'b1;
            fetch_data <= mrd(fetch_addr);
            nfetch++;
        end
        if (bus_req && !bus_ack && ($urandom % 3 != 0)) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                if (nact < 64) begin
                    act_addr[nact] = bus_addr;
                    act_data[nact] = bus_wdata;
                end
                nact++;
                regs[bus_addr[5:2]] = bus_wdata;
            end else begin
                bus_rdata <= regs[bus_addr[5:2]];
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference interpreter written from the requirements.
    task automatic ref_run(input logic [31:0] sa, output int en, output bit ed, output bit ee);
        logic [31:0] rm [16];
        logic [31:0] pc, h, off, cnd;
        bit halt;
        for (int i = 0; i < 16; i++) rm[i] = init_reg(i);
        pc = sa; cnd = 32'd0; en = 0; ed = 0; ee = 0; halt = 0;
        for (int step = 0; step < 60 && !halt; step++) begin
            h = mrd(pc);
            if (!h[31]) begin
                exp_addr[en] = h;
                exp_data[en] = mrd(pc + 4);
                rm[h[5:2]] = mrd(pc + 4);
                en++;
                pc = pc + 8;
            end else if (h == H_LOADC) begin
                cnd = rm[mrd(pc + 4) & 32'h3C >> 2] ;
                cnd = rm[mrd(pc + 4) >> 2 & 32'hF] & mrd(pc + 8);
                pc = pc + 12;
            end else if (h == H_JUMPC || h == H_JUMP) begin
                off = mrd(pc + 4);
                if (off == 0 || off[1:0] != 2'b00) begin
                    ee = 1; halt = 1;
                end else if (h == H_JUMP || cnd == mrd(pc + 8)) begin
                    pc = pc + off;
                end else begin
                    pc = pc + 12;
                end
            end else if (h == H_END) begin
                ed = 1; halt = 1;
            end else begin
                ee = 1; halt = 1;
            end
        end
    endtask

    task automatic e_word(input logic [31:0] w);
        mem[cur >> 2] = w;
        cur += 4;
    endtask
    task automatic e_write(input logic [31:0] a, input logic [31:0] d);
        e_word(a); e_word(d);
    endtask
    task automatic e_loadc(input logic [31:0] a, input logic [31:0] m);
        e_word(H_LOADC); e_word(a); e_word(m);
    endtask
    task automatic e_jumpc(input logic [31:0] off, input logic [31:0] c);
        e_word(H_JUMPC); e_word(off); e_word(c);
    endtask
    task automatic e_jump(input logic [31:0] off);
        e_word(H_JUMP); e_word(off);
    endtask

    task automatic run_prog(input logic [31:0] sa, input string req, input string what, input bit mid_start);
        int en, t, mism;
        bit ed, ee;
        for (int i = 0; i < 16; i++) regs[i] = init_reg(i);
        ref_run(sa, en, ed, ee);
        nact = 0;
        first_seen = 1'b0;
        @(negedge clk);
        start = 1'b1; start_addr = sa;
        @(negedge clk);
        start = 1'b0;
        if (mid_start) begin
            repeat (4) @(negedge clk);
            start = 1'b1; start_addr = sa + 32'h100;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!(done || error) && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk(req, {what, " status"}, {30'd0, done, error}, {30'd0, ed, ee});
        chk(req, {what, " write count"}, nact, en);
        mism = 0;
        for (int k = 0; k < en && k < nact && k < 64; k++)
            if (act_addr[k] !== exp_addr[k] || act_data[k] !== exp_data[k]) mism++;
        chk(req, {what, " write contents"}, mism, 0);
        chk("R1", {what, " first fetch at start_addr"}, first_faddr, sa);
    endtask

    task automatic gen_random(input logic [31:0] sa);
        int n, kind [12], sz [12], j, r;
        logic [31:0] ca [12];
        logic [31:0] off;
        n = 2 + $urandom % 8;
        for (int i = 0; i < n; i++) begin
            r = $urandom % 20;
            kind[i] = (r < 8) ? 0 : (r < 12) ? 1 : (r < 16) ? 2 : (r < 19) ? 3 : 4;
            sz[i] = (kind[i] == 0 || kind[i] == 3) ? 8 : (kind[i] == 4) ? 4 : 12;
        end
        ca[0] = sa;
        for (int i = 1; i <= n; i++) ca[i] = ca[i-1] + sz[i-1];
        cur = sa;
        for (int i = 0; i < n; i++) begin
            j = i + 1 + $urandom % (n - i);
            off = ca[j] - ca[i];
            if ($urandom % 12 == 0) off = ($urandom % 2) ? 32'd0 : off + 2;
            case (kind[i])
                0: e_write(($urandom % 16) << 2, ($urandom % 4) << 4);
                1: e_loadc(($urandom % 16) << 2, 32'h0000_00F0);
                2: e_jumpc(off, ($urandom % 4) << 4);
                3: e_jump(off);
                default: e_word(32'h8100_0000 + $urandom % 256);
            endcase
        end
        e_word(H_END);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_set, nf;
        seed_set = $urandom(32'd4242);
        for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
        for (int i = 0; i < 16; i++) regs[i] = init_reg(i);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset done", done, 0);
        chk("R1", "reset error", error, 0);
        chk("R1", "reset fetch_req", fetch_req, 0);
        chk("R1", "reset bus_req", bus_req, 0);

        // R2 / R8: two writes then end
        cur = 0;
        e_write(32'h10, 32'h0000_0011);
        e_write(32'h14, 32'h0000_0022);
        e_word(H_END);
        nf = nfetch;
        run_prog(32'h0, "R2", "plain writes", 1'b0);
        chk("R10", "each word fetched once", nfetch - nf, 5);
        chk("R8", "done set", done, 1);
        repeat (10) @(negedge clk);
        chk("R11", "done held", done, 1);
        chk("R10", "fetch/bus overlap", overlap, 0);

        // R11: start while running ignored
        run_prog(32'h0, "R11", "start during run", 1'b1);

        // R3 / R4 / R6: revision style skip, taken (reg 2 masks to 0x20)
        cur = 32'h40;
        e_loadc(32'h08, 32'h0000_00F0);
        e_jumpc(32'h14, 32'h0000_0020);
        e_jump(32'h10);
        e_write(32'h30, 32'h0000_00AA);
        e_write(32'h34, 32'h0000_00BB);
        e_word(H_END);
        run_prog(32'h40, "R4", "jumpc taken", 1'b0);
        chk("R6", "taken path write count", nact, 2);
        chk("R3", "masked load drove branch", act_addr[0], 32'h30);

        // R4 / R5: not taken (reg 3 masks to 0x30), unconditional jump used
        mem[(32'h40 >> 2) + 1] = 32'h0C;
        run_prog(32'h40, "R5", "jumpc not taken", 1'b0);
        chk("R5", "jump skipped first write", act_addr[0], 32'h34);

        // R1: condition cleared by start, compare with zero taken
        cur = 32'h100;
        e_jumpc(32'h14, 32'h0);
        e_jump(32'h10);
        e_write(32'h20, 32'h0000_0001);
        e_write(32'h24, 32'h0000_0002);
        e_word(H_END);
        run_prog(32'h100, "R1", "cleared condition", 1'b0);
        chk("R1", "cleared condition writes", nact, 2);

        // R7: zero offset on jump
        cur = 32'h140;
        e_write(32'h28, 32'h5);
        e_jump(32'h0);
        e_word(H_END);
        run_prog(32'h140, "R7", "zero offset", 1'b0);
        nf = nfetch;
        repeat (10) @(negedge clk);
        chk("R7", "no fetch after error", nfetch - nf, 0);
        chk("R7", "fetch_req low in error", fetch_req, 0);
        chk("R11", "error held", error, 1);

        // R7: unaligned offset on an untaken conditional jump
        cur = 32'h160;
        e_jumpc(32'h6, 32'h1234);
        e_word(H_END);
        run_prog(32'h160, "R7", "unaligned offset", 1'b0);

        // R9: unknown header after a write
        cur = 32'h180;
        e_write(32'h2C, 32'h7);
        e_word(32'h8123_0000);
        e_write(32'h30, 32'h8);
        e_word(H_END);
        run_prog(32'h180, "R9", "unknown header", 1'b0);
        chk("R9", "error set", error, 1);

        // Random scripts (R2..R6)
        for (int p = 0; p < 40; p++) begin
            for (int i = 128; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
            gen_random(32'h200);
            run_prog(32'h200, "R4", "random script", 1'b0);
        end
        chk("R10", "fetch/bus overlap overall", overlap, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule